// File: doc/BRIEF.md
# Reset Strap Latch and Decoder

This block records the levels on four configuration pads while the chip sits in system reset. It freezes them as strap bits that survive every later reset-free cycle, until a power-down indication clears them. Five reset sources can each open the sampling window: power-on, RTC watchdog, brownout, analog super-watchdog and crystal-glitch detection. The pads pass through a synchronizer first. The latch follows the synchronized pad word on every clock while the window is open. The last word it loads before the window closes is the one that is kept.

The frozen straps are decoded together with two one-time-programmable fuse fields into boot-time controls:

- the boot mode;
- a flag that allows the boot ROM to print on the serial console;
- a select that routes JTAG either from the chip pins or from the USB serial/JTAG controller;
- a flag for the strap combination that is not allowed.

Three of the strap bits are also presented as a status field for software.

Top module: `strap_boot_ctrl`

## Requirements
- R1: While any bit of `rst_src` is 1 and `pwr_dn` is 0, the latch loads the synchronized pad word on every clock edge, whichever reset source is active.
- R2: Once every `rst_src` bit is 0, the latched straps hold, and any later change on `pad_in` has no effect on the outputs.
- R3: `pwr_dn` = 1 forces the latch and synchronizer to the default pattern, which is pad_in[2] = 1 and the other bits 0. This takes priority over an open reset window in the same cycle.
- R4: Pads pass two synchronizer flops before the latch. A pad change made in the last two clock cycles before the window closes is not captured.
- R5: `strap_stat` = {pad_in[3], pad_in[1], pad_in[0]} as latched, so bit 2 is pad D, bit 1 is pad B and bit 0 is pad A.
- R6: `boot_mode` is 2'b00 (SPI boot) when latched pad C = 1, whatever pad B is. It is 2'b01 (download) when C = 0 and B = 1, and 2'b10 when C = 0 and B = 0.
- R7: `strap_bad` is 1 exactly when latched pad B = 0 and pad C = 0.
- R8: `print_en` depends on `fuse_print` and latched pad B. It is 1 for fuse 0 and 0 for fuse 3. For fuse 1 it is the inverse of B, and for fuse 2 it equals B.
- R9: `jtag_pins` is 0 (USB controller source) when `fuse_jtag` = 0. When `fuse_jtag` = 1 it is the inverse of latched pad D, so D = 0 routes JTAG from the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| pwr_dn | input | 1 | Power-down indication; clears the strap state |
| rst_src | input | NUM_RST_SRC | One bit per system reset source; any bit set opens the sampling window |
| pad_in | input | 4 | Raw pad levels: [0]=A, [1]=B, [2]=C, [3]=D |
| fuse_print | input | 2 | Console print control fuse field |
| fuse_jtag | input | 1 | JTAG source select fuse |
| strap_stat | output | 3 | Latched {D, B, A} for the status register |
| boot_mode | output | 2 | 00 SPI, 01 download, 10 invalid |
| print_en | output | 1 | Boot ROM console print allowed |
| jtag_pins | output | 1 | 1: JTAG from chip pins, 0: from USB serial/JTAG controller |
| strap_bad | output | 1 | Invalid strap combination latched |

## Verification
The two functions that can fall in the same cycle are the power-down clear and the reset-window capture. Either can rewrite the latch on the same edge.

The bench provokes the overlap in one sequence. It opens a reset window with the pads set to the invalid all-zero word and raises `pwr_dn` while the window is open. It then drops both on the same clock.

The result is judged at the ports. `strap_stat` must read zero, `boot_mode` must read SPI, and `strap_bad` must stay low. This shows the clear won and nothing from the open window got through.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int STRAP_W = 4;
  localparam int IDX_A   = 0;
  localparam int IDX_B   = 1;
  localparam int IDX_C   = 2;
  localparam int IDX_D   = 3;
  localparam int STAT_W  = 3;
  localparam logic [STRAP_W-1:0] STRAP_DEFAULT = 4'b0100;

  typedef enum logic [1:0] {
    BOOT_SPI = 2'b00,
    BOOT_DL  = 2'b01,
    BOOT_BAD = 2'b10
  } boot_mode_e;

  function automatic boot_mode_e f_boot_mode(input logic pin_b, input logic pin_c);
    if (pin_c)      return BOOT_SPI;
    else if (pin_b) return BOOT_DL;
    else            return BOOT_BAD;
  endfunction

  function automatic logic f_print(input logic [1:0] fuse, input logic pin_b);
    case (fuse)
      2'd0:    return 1'b1;
      2'd1:    return ~pin_b;
      2'd2:    return pin_b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic f_jtag_pins(input logic fuse, input logic pin_d);
    return fuse & ~pin_d;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] CLR_VAL = '0
) (
  input  logic         clk,
  input  logic         clr,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (clr) stg[0] <= CLR_VAL;
        else     stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (clr) stg[s] <= CLR_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/strap_hold.sv
module strap_hold
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               clr,
  input  logic               win_open,
  input  logic [STRAP_W-1:0] d,
  output logic [STRAP_W-1:0] q
);
  logic load_now;
  assign load_now = win_open & ~clr;

  always_ff @(posedge clk) begin
    if (clr)           q <= STRAP_DEFAULT;
    else if (load_now) q <= d;
  end

  p_capture_r1: assert property (@(posedge clk) disable iff (clr)
    win_open |=> (q == $past(d)));
  p_hold_r2: assert property (@(posedge clk) disable iff (clr)
    (!win_open && !$past(clr)) |=> $stable(q));
  p_clear_r3: assert property (@(posedge clk) disable iff (clr)
    $fell(clr) |-> (q == STRAP_DEFAULT));
endmodule

// File: rtl/strap_decode.sv
module strap_decode
  import strap_pkg::*;
(
  input  logic               clk,
  input  logic               clr,
  input  logic [STRAP_W-1:0] strap,
  input  logic [1:0]         fuse_print,
  input  logic               fuse_jtag,
  output logic [STAT_W-1:0]  stat,
  output logic [1:0]         boot_mode,
  output logic               print_en,
  output logic               jtag_pins,
  output logic               strap_bad
);
  boot_mode_e mode;

  always_comb begin
    mode      = f_boot_mode(strap[IDX_B], strap[IDX_C]);
    boot_mode = mode;
    strap_bad = ~strap[IDX_B] & ~strap[IDX_C];
    print_en  = f_print(fuse_print, strap[IDX_B]);
    jtag_pins = f_jtag_pins(fuse_jtag, strap[IDX_D]);
    stat      = {strap[IDX_D], strap[IDX_B], strap[IDX_A]};
  end

  p_bad_mode_r7: assert property (@(posedge clk) disable iff (clr)
    strap_bad |-> (boot_mode == BOOT_BAD));
  p_spi_mode_r6: assert property (@(posedge clk) disable iff (clr)
    strap[IDX_C] |-> (boot_mode == BOOT_SPI && !strap_bad));
  p_print_on_r8: assert property (@(posedge clk) disable iff (clr)
    (fuse_print == 2'd0) |-> print_en);
  p_print_off_r8: assert property (@(posedge clk) disable iff (clr)
    (fuse_print == 2'd3) |-> !print_en);
  p_jtag_usb_r9: assert property (@(posedge clk) disable iff (clr)
    !fuse_jtag |-> !jtag_pins);
endmodule

// File: rtl/strap_boot_ctrl.sv
module strap_boot_ctrl
  import strap_pkg::*;
#(
  parameter int NUM_RST_SRC = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   pwr_dn,
  input  logic [NUM_RST_SRC-1:0] rst_src,
  input  logic [STRAP_W-1:0]     pad_in,
  input  logic [1:0]             fuse_print,
  input  logic                   fuse_jtag,
  output logic [STAT_W-1:0]      strap_stat,
  output logic [1:0]             boot_mode,
  output logic                   print_en,
  output logic                   jtag_pins,
  output logic                   strap_bad
);
  logic               win_open;
  logic [STRAP_W-1:0] pad_sync;
  logic [STRAP_W-1:0] strap_q;

  assign win_open = |rst_src;

  strap_sync #(
    .W(STRAP_W), .STAGES(SYNC_STAGES), .CLR_VAL(STRAP_DEFAULT)
  ) u_sync (
    .clk(clk), .clr(pwr_dn), .d(pad_in), .q(pad_sync)
  );

  strap_hold u_hold (
    .clk(clk), .clr(pwr_dn), .win_open(win_open), .d(pad_sync), .q(strap_q)
  );

  strap_decode u_dec (
    .clk(clk), .clr(pwr_dn), .strap(strap_q),
    .fuse_print(fuse_print), .fuse_jtag(fuse_jtag),
    .stat(strap_stat), .boot_mode(boot_mode), .print_en(print_en),
    .jtag_pins(jtag_pins), .strap_bad(strap_bad)
  );

  p_closed_stable_r2: assert property (@(posedge clk) disable iff (pwr_dn)
    (!win_open && !$past(pwr_dn)) |=> $stable(strap_stat));
endmodule

// File: tb/strap_boot_ctrl_tb.sv
`timescale 1ns/1ps
module strap_boot_ctrl_tb;
  localparam int NSRC = 5;

  logic            clk = 1'b0;
  logic            pwr_dn;
  logic [NSRC-1:0] rst_src;
  logic [3:0]      pad_in;
  logic [1:0]      fuse_print;
  logic            fuse_jtag;
  logic [2:0]      strap_stat;
  logic [1:0]      boot_mode;
  logic            print_en;
  logic            jtag_pins;
  logic            strap_bad;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  strap_boot_ctrl #(.NUM_RST_SRC(NSRC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .pwr_dn(pwr_dn), .rst_src(rst_src), .pad_in(pad_in),
    .fuse_print(fuse_print), .fuse_jtag(fuse_jtag), .strap_stat(strap_stat),
    .boot_mode(boot_mode), .print_en(print_en), .jtag_pins(jtag_pins),
    .strap_bad(strap_bad)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input logic [3:0] p);
    return p[2] ? 2'd0 : (p[1] ? 2'd1 : 2'd2);
  endfunction

  function automatic logic exp_print(input logic [1:0] f, input logic b);
    return (f[1] ^ f[0]) ? (b ^ f[0]) : ~f[1];
  endfunction

  task automatic boot(input logic [3:0] p, input int src);
    @(negedge clk);
    pad_in = p;
    rst_src = NSRC'(1) << src;
    repeat (4) @(negedge clk);
    rst_src = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_straps(input logic [3:0] p, input string tag);
    chk({tag, " R5 stat"}, 8'(strap_stat), 8'({p[3], p[1], p[0]}));
    chk({tag, " R6 mode"}, 8'(boot_mode), 8'(exp_mode(p)));
    chk({tag, " R7 bad"}, 8'(strap_bad), 8'(!p[1] && !p[2]));
  endtask

  initial begin
    pwr_dn = 1'b1;
    rst_src = '0;
    pad_in = 4'h0;
    fuse_print = 2'd0;
    fuse_jtag = 1'b0;
    repeat (3) @(negedge clk);
    pwr_dn = 1'b0;
    @(negedge clk);
    check_straps(4'b0100, "reset R3");

    // R1 sweep over all pad words, rotating through the reset sources
    for (int p = 0; p < 16; p++) begin
      boot(4'(p), p % NSRC);
      check_straps(4'(p), "sweep R1");
      for (int f = 0; f < 4; f++) begin
        fuse_print = 2'(f);
        #0.5;
        chk("R8 print", 8'(print_en), 8'(exp_print(2'(f), p[1])));
      end
      for (int j = 0; j < 2; j++) begin
        fuse_jtag = j[0];
        #0.5;
        chk("R9 jtag", 8'(jtag_pins), 8'(j[0] && !p[3]));
      end
    end

    // R2: pads toggle after the window closed
    boot(4'b1010, 2);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      pad_in = ~pad_in;
    end
    repeat (3) @(negedge clk);
    check_straps(4'b1010, "hold R2");

    // R4: change inside the last two cycles is missed
    @(negedge clk);
    pad_in = 4'b0011;
    rst_src = 5'b00001;
    repeat (4) @(negedge clk);
    pad_in = 4'b1100;
    @(negedge clk);
    rst_src = '0;
    repeat (2) @(negedge clk);
    check_straps(4'b0011, "late R4");

    // R3: power-down overlapping an open window with the invalid word
    @(negedge clk);
    pad_in = 4'b0000;
    rst_src = 5'b10000;
    repeat (3) @(negedge clk);
    pwr_dn = 1'b1;
    repeat (3) @(negedge clk);
    pwr_dn = 1'b0;
    rst_src = '0;
    repeat (2) @(negedge clk);
    check_straps(4'b0100, "clear R3");

    // After a clear, the next reset samples afresh
    boot(4'b1001, 3);
    check_straps(4'b1001, "resample R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule